// File: doc/BRIEF.md
# DDS Phase Generator with Frequency and Phase Keying

This block is the phase path of a direct digital synthesizer. A 48-bit accumulator adds an active frequency word on every clock. The upper 14 bits of the accumulator, plus a selected phase offset, form the phase word. That phase word feeds a later phase-to-amplitude stage, which is not part of this block.

Two frequency words and two phase offsets are held in registers. External select inputs choose between them. In frequency keying, the output can jump from one frequency to the other at once. It can also glide between them in equal steps, at a programmable rate, so that the spectrum stays cleaner. In phase keying, the output phase jumps at once when the select input changes.

All registers are loaded through a single-cycle write port. Any register can be rewritten while the accumulator keeps running.

Top module: `dds_phase_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the accumulator, every register, the glide state and the glide divider counter are cleared. After that edge, `phase_out` and `freq_word` read 0 and the mode is tone (code 0).
- R2: A write is seen on the edge where `wr_en` is high, and the register holds the new value from that edge on. The addresses are:
  - 0: frequency word F0 (48 bits).
  - 1: frequency word F1 (48 bits).
  - 2: offset P0, taken from `wr_data[13:0]`.
  - 3: offset P1, taken from `wr_data[13:0]`.
  - 4: glide step size (48 bits).
  - 5: glide divider, taken from `wr_data[15:0]`.
  - 6: mode, taken from `wr_data[1:0]`.
  - A write to address 7 changes nothing.
- R3: On every edge the accumulator grows by `freq_word`, modulo 2^48. `phase_out` equals accumulator bits [47:34] plus the selected offset, modulo 2^14.
- R4: In mode 0 (tone), `freq_word` is F0 and the offset is P0. Both `fsk_sel` and `psk_sel` have no effect.
- R5: In mode 1 (stepped frequency keying), `freq_word` is F0 when `fsk_sel` is 0 and F1 when it is 1. The change shows in the same cycle as `fsk_sel` changes. The offset is P0.
- R6: In mode 2 (glided frequency keying), `freq_word` is the glide word. On every (divider+1)-th edge spent in this mode, the glide word moves toward the word picked by `fsk_sel` by the step size. It lands exactly on that word when the remaining distance is no larger than the step size. On all other edges it holds.
- R7: Outside mode 2, the glide word follows the word `fsk_sel` picks, and the divider counter stays at 0. A glide therefore starts from the word in use when mode 2 is entered.
- R8: In mode 3 (phase keying), `freq_word` is F0. `psk_sel` picks P0 (0) or P1 (1), and `phase_out` shifts in the same cycle as `psk_sel` changes.
- R9: Rewriting a frequency word or offset does not clear the accumulator. The new value is used from the next edge on, with the phase kept continuous.
- R10: Only the low 14 bits of an offset write are kept. Adding the offset wraps modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 48 | Write data |
| fsk_sel | input | 1 | Frequency word select |
| psk_sel | input | 1 | Phase offset select |
| phase_out | output | 14 | Truncated phase word with offset |
| freq_word | output | 48 | Frequency word in use this cycle |

## Verification
A wrong glide state shows on `freq_word` as soon as the next divider tick. If the glide word overshoots or stalls short of the target, `freq_word` never settles on the value that was written. A wrong accumulator step does not show on `phase_out` at once, because only the top 14 bits come out. The error builds up each cycle until it reaches bit 34, so the bench uses large frequency words that move the upper bits within a few cycles. A mux error in the offset or frequency selection shows at the ports in the same cycle as the select input changes, so the bench compares both outputs on every clock against a reference model.

// File: rtl/dds_pkg.sv
package dds_pkg;
   typedef enum logic [1:0] {
      MODE_TONE      = 2'd0,
      MODE_FSK_STEP  = 2'd1,
      MODE_FSK_GLIDE = 2'd2,
      MODE_PSK       = 2'd3
   } dds_mode_e;

   localparam int unsigned ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_FREQ0 = 3'd0;
   localparam logic [ADDR_W-1:0] A_FREQ1 = 3'd1;
   localparam logic [ADDR_W-1:0] A_OFS0  = 3'd2;
   localparam logic [ADDR_W-1:0] A_OFS1  = 3'd3;
   localparam logic [ADDR_W-1:0] A_STEP  = 3'd4;
   localparam logic [ADDR_W-1:0] A_DIV   = 3'd5;
   localparam logic [ADDR_W-1:0] A_MODE  = 3'd6;
endpackage

// File: rtl/dds_regs.sv
module dds_regs
   import dds_pkg::*;
#(
   parameter int unsigned ACC_W = 48,
   parameter int unsigned PH_W  = 14,
   parameter int unsigned DIV_W = 16
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   output logic [ACC_W-1:0]  freq0,
   output logic [ACC_W-1:0]  freq1,
   output logic [PH_W-1:0]   ofs0,
   output logic [PH_W-1:0]   ofs1,
   output logic [ACC_W-1:0]  step,
   output logic [DIV_W-1:0]  div,
   output dds_mode_e         mode
);
   always_ff @(posedge clk) begin
      if (rst) begin
         freq0 <= '0;
         freq1 <= '0;
         ofs0  <= '0;
         ofs1  <= '0;
         step  <= '0;
         div   <= '0;
         mode  <= MODE_TONE;
      end else if (wr_en) begin
         case (wr_addr)
            A_FREQ0: freq0 <= wr_data;
            A_FREQ1: freq1 <= wr_data;
            A_OFS0:  ofs0  <= wr_data[PH_W-1:0];
            A_OFS1:  ofs1  <= wr_data[PH_W-1:0];
            A_STEP:  step  <= wr_data;
            A_DIV:   div   <= wr_data[DIV_W-1:0];
            A_MODE:  mode  <= dds_mode_e'(wr_data[1:0]);
            default: ;
         endcase
      end
   end

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == A_MODE) |=> $stable(mode));
endmodule

// File: rtl/dds_freq_sel.sv
module dds_freq_sel
   import dds_pkg::*;
#(
   parameter int unsigned ACC_W   = 48,
   parameter int unsigned DIV_W   = 16,
   parameter bit          GLIDE_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  dds_mode_e        mode,
   input  logic             fsk_sel,
   input  logic [ACC_W-1:0] freq0,
   input  logic [ACC_W-1:0] freq1,
   input  logic [ACC_W-1:0] step,
   input  logic [DIV_W-1:0] div,
   output logic [ACC_W-1:0] freq_word
);
   logic [ACC_W-1:0] pick_word;
   assign pick_word = fsk_sel ? freq1 : freq0;

   generate
      if (GLIDE_EN) begin : g_glide
         logic [ACC_W-1:0] glide_q;
         logic [ACC_W-1:0] gap;
         logic [DIV_W-1:0] cnt_q;
         logic             in_glide;
         logic             rising;
         logic             tick;

         assign in_glide = (mode == MODE_FSK_GLIDE);
         assign rising   = pick_word > glide_q;
         assign gap      = rising ? (pick_word - glide_q) : (glide_q - pick_word);
         assign tick     = in_glide && (cnt_q == div);

         always_ff @(posedge clk) begin
            if (rst) begin
               glide_q <= '0;
               cnt_q   <= '0;
            end else if (!in_glide) begin
               glide_q <= pick_word;
               cnt_q   <= '0;
            end else if (tick) begin
               cnt_q <= '0;
               if (gap <= step)
                  glide_q <= pick_word;
               else if (rising)
                  glide_q <= glide_q + step;
               else
                  glide_q <= glide_q - step;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         always_comb begin
            case (mode)
               MODE_FSK_STEP:  freq_word = pick_word;
               MODE_FSK_GLIDE: freq_word = glide_q;
               default:        freq_word = freq0;
            endcase
         end

         // R6
         glide_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (in_glide && !tick) |=> $stable(glide_q));
         // R6
         glide_land_chk: assert property (@(posedge clk) disable iff (rst)
            (tick && gap <= step) |=> glide_q == $past(pick_word));
         // R7
         glide_idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
            !in_glide |=> cnt_q == '0);
      end else begin : g_step_only
         always_comb begin
            case (mode)
               MODE_FSK_STEP, MODE_FSK_GLIDE: freq_word = pick_word;
               default:                       freq_word = freq0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int unsigned ACC_W = 48,
   parameter int unsigned PH_W  = 14
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] freq_word,
   input  logic [PH_W-1:0]  offset,
   output logic [PH_W-1:0]  phase_out
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + freq_word;
   end

   assign phase_out = acc_q[ACC_W-1 -: PH_W] + offset;

   // R1
   acc_clear_chk: assert property (@(posedge clk) rst |=> acc_q == '0);
   // R3
   acc_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (freq_word == '0) |=> $stable(acc_q));
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
   import dds_pkg::*;
#(
   parameter int unsigned ACC_W    = 48,
   parameter int unsigned PH_W     = 14,
   parameter int unsigned DIV_W    = 16,
   parameter bit          GLIDE_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   input  logic              fsk_sel,
   input  logic              psk_sel,
   output logic [PH_W-1:0]   phase_out,
   output logic [ACC_W-1:0]  freq_word
);
   generate
      if (PH_W < 2 || PH_W > ACC_W) begin : g_bad_ph
         $error("PH_W must lie between 2 and ACC_W");
      end
      if (DIV_W < 1 || DIV_W > ACC_W) begin : g_bad_div
         $error("DIV_W must lie between 1 and ACC_W");
      end
   endgenerate

   logic [ACC_W-1:0] freq0, freq1, step;
   logic [PH_W-1:0]  ofs0, ofs1, ofs_sel;
   logic [DIV_W-1:0] div;
   dds_mode_e        mode;

   dds_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .freq0(freq0), .freq1(freq1), .ofs0(ofs0), .ofs1(ofs1),
      .step(step), .div(div), .mode(mode)
   );

   dds_freq_sel #(.ACC_W(ACC_W), .DIV_W(DIV_W), .GLIDE_EN(GLIDE_EN)) u_fsel (
      .clk(clk), .rst(rst), .mode(mode), .fsk_sel(fsk_sel),
      .freq0(freq0), .freq1(freq1), .step(step), .div(div),
      .freq_word(freq_word)
   );

   assign ofs_sel = (mode == MODE_PSK && psk_sel) ? ofs1 : ofs0;

   dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
      .clk(clk), .rst(rst), .freq_word(freq_word), .offset(ofs_sel),
      .phase_out(phase_out)
   );

   // R4
   tone_word_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_TONE) |-> freq_word == freq0);
   // R5
   fsk_step_word_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_FSK_STEP) |-> freq_word == (fsk_sel ? freq1 : freq0));
   // R8
   psk_word_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_PSK) |-> freq_word == freq0);
endmodule

// File: tb/sim_dds_phase_gen.sv
module sim_dds_phase_gen;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [47:0] wr_data = '0;
   logic        fsk_sel = 1'b0;
   logic        psk_sel = 1'b0;
   logic [13:0] phase_out;
   logic [47:0] freq_word;

   always #5 clk = ~clk;

   dds_phase_gen u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fsk_sel(fsk_sel), .psk_sel(psk_sel), .phase_out(phase_out), .freq_word(freq_word)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   typedef struct {
      logic [13:0] ph;
      logic [47:0] fw;
   } exp_t;
   exp_t exp_q[$];

   // reference model state
   logic [47:0] m_f0, m_f1, m_step, m_acc, m_glide;
   logic [13:0] m_o0, m_o1;
   logic [15:0] m_div, m_cnt;
   logic [1:0]  m_mode;

   function automatic logic [47:0] m_freq();
      case (m_mode)
         2'd1:    return fsk_sel ? m_f1 : m_f0;
         2'd2:    return m_glide;
         default: return m_f0;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [47:0] act, input logic [47:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
      end
   endtask

   // model: advances on each edge and pushes the expected outputs
   always @(posedge clk) begin
      logic [47:0] f, tgt, gap;
      exp_t e;
      if (rst) begin
         m_f0 = '0; m_f1 = '0; m_step = '0; m_acc = '0; m_glide = '0;
         m_o0 = '0; m_o1 = '0; m_div = '0; m_cnt = '0; m_mode = '0;
      end else begin
         f     = m_freq();
         m_acc = m_acc + f;
         tgt   = fsk_sel ? m_f1 : m_f0;
         if (m_mode != 2'd2) begin
            m_glide = tgt;
            m_cnt   = '0;
         end else if (m_cnt == m_div) begin
            m_cnt = '0;
            gap = (tgt > m_glide) ? tgt - m_glide : m_glide - tgt;
            if (gap <= m_step)      m_glide = tgt;
            else if (tgt > m_glide) m_glide = m_glide + m_step;
            else                    m_glide = m_glide - m_step;
         end else begin
            m_cnt = m_cnt + 16'd1;
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_f0   = wr_data;
               3'd1: m_f1   = wr_data;
               3'd2: m_o0   = wr_data[13:0];
               3'd3: m_o1   = wr_data[13:0];
               3'd4: m_step = wr_data;
               3'd5: m_div  = wr_data[15:0];
               3'd6: m_mode = wr_data[1:0];
               default: ;
            endcase
         end
      end
      e.fw = m_freq();
      e.ph = m_acc[47:34] + ((m_mode == 2'd3 && psk_sel) ? m_o1 : m_o0);
      exp_q.push_back(e);
   end

   // monitor: compares away from the edge
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         check(cur_req, "phase_out", {34'd0, phase_out}, {34'd0, e.ph});
         check(cur_req, "freq_word", freq_word, e.fw);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [47:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not end actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1: reset state
      idle(3);
      check("R1", "reset phase", {34'd0, phase_out}, 48'd0);
      check("R1", "reset freq", freq_word, 48'd0);
      rst = 1'b0;

      // R4: tone ignores both selects; R2 write timing
      cur_req = "R4";
      wr(3'd0, 48'h0123_4567_89AB);
      wr(3'd2, 48'd100);
      wr(3'd1, 48'h0800_0000_0000);
      wr(3'd3, 48'hFFFF_FFFF_3FF0);       // R10: only low 14 bits kept
      idle(4);
      fsk_sel = 1'b1; idle(3);
      psk_sel = 1'b1; idle(3);
      fsk_sel = 1'b0; psk_sel = 1'b0;

      // R2: address 7 changes nothing
      cur_req = "R2";
      wr(3'd7, 48'hFFFF_FFFF_FFFF);
      idle(5);

      // R5: stepped frequency keying
      cur_req = "R5";
      wr(3'd6, 48'd1);
      idle(3);
      fsk_sel = 1'b1; idle(4);
      fsk_sel = 1'b0; idle(2);
      fsk_sel = 1'b1; idle(1);

      // R6 / R7: glide between close words; 0xA00 gap, step 0x300, divider 2
      cur_req = "R7";
      wr(3'd0, 48'h0400_0000_0000);
      wr(3'd1, 48'h0400_0000_0A00);
      wr(3'd4, 48'h0000_0000_0300);
      wr(3'd5, 48'd2);
      fsk_sel = 1'b0;
      idle(2);
      wr(3'd6, 48'd2);
      cur_req = "R6";
      idle(4);
      fsk_sel = 1'b1; idle(20);            // rises and lands on F1
      fsk_sel = 1'b0; idle(20);            // falls and lands on F0
      fsk_sel = 1'b1; idle(5);             // leave mid-glide
      cur_req = "R7";
      wr(3'd6, 48'd1);
      idle(4);

      // R8 / R10: phase keying with offset wrap
      cur_req = "R8";
      wr(3'd0, 48'h1234_5678_9ABC);
      wr(3'd6, 48'd3);
      idle(3);
      psk_sel = 1'b1; idle(3);
      psk_sel = 1'b0; idle(2);
      cur_req = "R10";
      wr(3'd2, 48'hABCD_0000_3FFF);
      psk_sel = 1'b1; idle(3);

      // R9 / R3: rewrite while running, large word wraps the accumulator
      cur_req = "R9";
      wr(3'd0, 48'hFFF0_0000_0001);
      idle(6);
      cur_req = "R3";
      wr(3'd0, 48'h7FFF_FFFF_FFFF);
      idle(8);

      // R1: reset in mid-run clears everything
      cur_req = "R1";
      @(negedge clk); rst = 1'b1;
      idle(2);
      check("R1", "mid-run reset phase", {34'd0, phase_out}, 48'd0);
      check("R1", "mid-run reset freq", freq_word, 48'd0);
      rst = 1'b0;
      idle(4);
      finish_run();
   end
endmodule